// File: doc/BRIEF.md
# DTMF Tone Pair Decoder

This block turns two limited square waves into a decoded telephone keypad symbol. One input comes from the low-group band and one from the high-group band. Each input is timed by counting system clocks between its rising edges. The measured period is then compared against eight window ranges, one for each standard DTMF frequency. These ranges are computed at elaboration from the clock rate and a tolerance given in parts per thousand.

A group is treated as carrying a tone only after several back-to-back periods land in the same window. Short bursts of voice-like energy, which wander between windows, are therefore turned away. While both groups hold a tone, the early-steering output is high and a 4-bit code for the pair is shown. The code stays unchanged after the pair goes away. Validation of the pair's duration and of the pause between digits is left to steering logic outside this block.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: Each input's period is the number of clock cycles between two successive rising edges. The nominal period of a tone of f Hz is CLK_HZ/f.
- R2: A period p matches the tone f when floor(CLK_HZ*1000/(f*(1000+TOL_PERMIL))) <= p <= floor(CLK_HZ*1000/(f*(1000-TOL_PERMIL))), with both bounds inclusive. The low tones are 697, 770, 852 and 941 Hz (rows 0 to 3). The high tones are 1209, 1336, 1477 and 1633 Hz (columns 0 to 3).
- R3: After an idle state, the first rising edge only arms the group. The group becomes valid once VALID_RUN (default 4) consecutive measured periods fall in the same window.
- R4: A measured period that lies in no window makes the group invalid at once and clears its run.
- R5: If no rising edge arrives within TIMEOUT = 2 * (upper bound of the 697 Hz window) cycles, the group becomes invalid and returns to idle.
- R6: earlySteer goes high one cycle after both groups are valid. It stays low while only one group is valid.
- R7: earlySteer falls one cycle after either group loses validity.
- R8: digitCode for row r and column c is as follows. For keys 1 to 9 it is 3r+c+1. Key 0 (r3,c1) is 1010. Key * (r3,c0) is 1011. Key # (r3,c2) is 1100. Keys A, B, C and D (column 3, rows 0 to 3) are 1101, 1110, 1111 and 0000.
- R9: Reset clears earlySteer and digitCode to 0. digitCode changes only while earlySteer is high, so it holds the last pair after earlySteer falls.
- R10: A valid period in a window different from the current run restarts the run at length one, so the group stays invalid until VALID_RUN periods agree again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that the period counters run on |
| rstN | input | 1 | Active-low synchronous reset |
| lowTone | input | 1 | Limited square wave of the low-frequency group (asynchronous) |
| highTone | input | 1 | Limited square wave of the high-frequency group (asynchronous) |
| earlySteer | output | 1 | High while both groups carry a valid tone |
| digitCode | output | 4 | Code of the most recently detected tone pair |

## Verification
The checker watches several rules on every cycle:
- earlySteer rises only after both groups were valid, and falls one cycle after either one is lost.
- A group becomes valid only on a rising edge.
- A timeout or an out-of-band period leaves the group invalid on the next cycle.
- digitCode never moves while earlySteer is low.

Other behaviour can only be shown by the directed scenarios:
- the exact window edges;
- the code value for each row and column;
- the number of periods needed before acceptance;
- the restart after a change of window;
- rejection of a single-group tone.

// File: rtl/dtmf_decoder_pkg.sv
package dtmf_decoder_pkg;

  localparam int NUM_GROUPS = 2;
  localparam int NUM_BINS   = 4;

  typedef logic [1:0] binIdx_t;

  // Per-group observations from the datapath to the control.
  typedef struct packed {
    logic rise;     // synchronised rising edge this cycle
    logic timeout;  // edge-free window just expired
    logic hit;      // current count lies in some window
    logic sameBin;  // hit, in the window of the running streak
    logic runFull;  // streak reached the acceptance length
  } groupStatus_t;

  // Strobes from the control into one group's run tracker.
  typedef struct packed {
    logic runClear;
    logic runStart;
    logic runStep;
  } groupStrobe_t;

  function automatic int nominalHz(input int grp, input int idx);
    int hz;
    if (grp == 0) begin
      case (idx)
        0:       hz = 697;
        1:       hz = 770;
        2:       hz = 852;
        default: hz = 941;
      endcase
    end else begin
      case (idx)
        0:       hz = 1209;
        1:       hz = 1336;
        2:       hz = 1477;
        default: hz = 1633;
      endcase
    end
    return hz;
  endfunction

  function automatic int binMinCount(input int clkHz, input int tolPermil,
                                     input int grp, input int idx);
    longint num;
    longint den;
    num = longint'(clkHz) * 1000;
    den = longint'(nominalHz(grp, idx)) * (1000 + tolPermil);
    return int'(num / den);
  endfunction

  function automatic int binMaxCount(input int clkHz, input int tolPermil,
                                     input int grp, input int idx);
    longint num;
    longint den;
    num = longint'(clkHz) * 1000;
    den = longint'(nominalHz(grp, idx)) * (1000 - tolPermil);
    return int'(num / den);
  endfunction

  // Row = low-group window, column = high-group window.
  function automatic logic [3:0] pairCode(input binIdx_t row, input binIdx_t col);
    logic [3:0] code;
    if (col == 2'd3) begin
      code = 4'(4'd13 + {2'b00, row});
    end else if (row == 2'd3) begin
      case (col)
        2'd0:    code = 4'b1011;
        2'd1:    code = 4'b1010;
        default: code = 4'b1100;
      endcase
    end else begin
      code = 4'(3 * row + col + 1);
    end
    return code;
  endfunction

endpackage

// File: rtl/dtmf_datapath.sv
module dtmf_datapath
  import dtmf_decoder_pkg::*;
#(
  parameter int CLK_HZ     = 200_000,
  parameter int TOL_PERMIL = 25,
  parameter int VALID_RUN  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_GROUPS-1:0]         toneIn,
  input  groupStrobe_t [NUM_GROUPS-1:0] strobes,
  input  logic                          codeLoad,
  output groupStatus_t [NUM_GROUPS-1:0] status,
  output logic [3:0]                    codeOut
);

  localparam int TIMEOUT_CNT = 2 * binMaxCount(CLK_HZ, TOL_PERMIL, 0, 0);
  localparam int CNT_W       = $clog2(TIMEOUT_CNT + 1);
  localparam int RUN_W       = $clog2(VALID_RUN + 1);

  binIdx_t [NUM_GROUPS-1:0] runBin;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic             syncA, syncB, prevQ;
    logic             rise;
    logic [CNT_W-1:0] cntQ;
    logic [NUM_BINS-1:0] hitVec;
    binIdx_t          hitIdx;
    binIdx_t          binQ;
    logic [RUN_W-1:0] runQ;

    // Two-stage synchroniser plus edge history.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        prevQ <= 1'b0;
      end else begin
        syncA <= toneIn[g];
        syncB <= syncA;
        prevQ <= syncB;
      end
    end

    assign rise = syncB & ~prevQ;

    // Period counter, saturating at the timeout limit (idle).
    always_ff @(posedge clk) begin
      if (!rstN)                               cntQ <= CNT_W'(TIMEOUT_CNT);
      else if (rise)                           cntQ <= CNT_W'(1);
      else if (cntQ != CNT_W'(TIMEOUT_CNT))    cntQ <= cntQ + CNT_W'(1);
    end

    // Window comparators, one per nominal frequency.
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      localparam int MIN_C = binMinCount(CLK_HZ, TOL_PERMIL, g, b);
      localparam int MAX_C = binMaxCount(CLK_HZ, TOL_PERMIL, g, b);
      assign hitVec[b] = (cntQ >= CNT_W'(MIN_C)) && (cntQ <= CNT_W'(MAX_C));
    end

    always_comb begin
      hitIdx = '0;
      for (int b = NUM_BINS - 1; b >= 0; b--) begin
        if (hitVec[b]) hitIdx = binIdx_t'(b);
      end
    end

    // Run tracker driven by control strobes.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        binQ <= '0;
        runQ <= '0;
      end else if (strobes[g].runClear) begin
        runQ <= '0;
      end else if (strobes[g].runStart) begin
        binQ <= hitIdx;
        runQ <= RUN_W'(1);
      end else if (strobes[g].runStep && runQ != RUN_W'(VALID_RUN)) begin
        runQ <= runQ + RUN_W'(1);
      end
    end

    assign runBin[g]         = binQ;
    assign status[g].rise    = rise;
    assign status[g].timeout = !rise && (cntQ == CNT_W'(TIMEOUT_CNT - 1));
    assign status[g].hit     = |hitVec;
    assign status[g].sameBin = (|hitVec) && (hitIdx == binQ) && (runQ != '0);
    assign status[g].runFull = (runQ == RUN_W'(VALID_RUN));
  end

  always_ff @(posedge clk) begin
    if (!rstN)         codeOut <= 4'b0000;
    else if (codeLoad) codeOut <= pairCode(runBin[0], runBin[1]);
  end

endmodule

// File: rtl/dtmf_control.sv
module dtmf_control
  import dtmf_decoder_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  groupStatus_t [NUM_GROUPS-1:0] status,
  output groupStrobe_t [NUM_GROUPS-1:0] strobes,
  output logic                          codeLoad,
  output logic                          estOut
);

  logic [NUM_GROUPS-1:0] armedQ;
  logic                  pairValid;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_ctl
    always_comb begin
      strobes[g] = '0;
      if (status[g].timeout) begin
        strobes[g].runClear = 1'b1;
      end else if (status[g].rise) begin
        if (!armedQ[g])                              strobes[g].runClear = 1'b1;
        else if (status[g].hit && status[g].sameBin) strobes[g].runStep  = 1'b1;
        else if (status[g].hit)                      strobes[g].runStart = 1'b1;
        else                                         strobes[g].runClear = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                  armedQ[g] <= 1'b0;
      else if (status[g].timeout) armedQ[g] <= 1'b0;
      else if (status[g].rise)    armedQ[g] <= 1'b1;
    end
  end

  assign pairValid = status[0].runFull && status[1].runFull;
  assign codeLoad  = pairValid;

  always_ff @(posedge clk) begin
    if (!rstN) estOut <= 1'b0;
    else       estOut <= pairValid;
  end

endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder
  import dtmf_decoder_pkg::*;
#(
  parameter int CLK_HZ     = 200_000,
  parameter int TOL_PERMIL = 25,
  parameter int VALID_RUN  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowTone,
  input  logic       highTone,
  output logic       earlySteer,
  output logic [3:0] digitCode
);

  groupStatus_t [NUM_GROUPS-1:0] status;
  groupStrobe_t [NUM_GROUPS-1:0] strobes;
  logic                          codeLoad;

  dtmf_datapath #(
    .CLK_HZ(CLK_HZ), .TOL_PERMIL(TOL_PERMIL), .VALID_RUN(VALID_RUN)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .toneIn({highTone, lowTone}),
    .strobes(strobes), .codeLoad(codeLoad),
    .status(status), .codeOut(digitCode)
  );

  dtmf_control i_control (
    .clk(clk), .rstN(rstN), .status(status),
    .strobes(strobes), .codeLoad(codeLoad), .estOut(earlySteer)
  );

endmodule

// File: rtl/dtmf_pair_decoder_checker.sv
module dtmf_pair_decoder_checker
  import dtmf_decoder_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          earlySteer,
  input logic [3:0]                    digitCode,
  input groupStatus_t [NUM_GROUPS-1:0] status
);

  assert_est_needs_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(earlySteer) |-> $past(status[0].runFull && status[1].runFull));

  assert_est_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(status[0].runFull && status[1].runFull) |=> !earlySteer);

  assert_low_valid_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0].runFull) |-> $past(status[0].rise));

  assert_high_valid_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[1].runFull) |-> $past(status[1].rise));

  assert_low_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    status[0].timeout |=> !status[0].runFull);

  assert_high_timeout_R5: assert property (@(posedge clk) disable iff (!rstN)
    status[1].timeout |=> !status[1].runFull);

  assert_low_out_of_band_R4: assert property (@(posedge clk) disable iff (!rstN)
    status[0].rise && !status[0].hit |=> !status[0].runFull);

  assert_high_out_of_band_R4: assert property (@(posedge clk) disable iff (!rstN)
    status[1].rise && !status[1].hit |=> !status[1].runFull);

  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !earlySteer |-> $stable(digitCode));

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_checker i_checker (
  .clk(clk), .rstN(rstN), .earlySteer(earlySteer),
  .digitCode(digitCode), .status(status)
);

// File: tb/test_dtmf_pair_decoder.sv
module test_dtmf_pair_decoder;

  localparam int CLK_HZ  = 200_000;
  localparam int TOL     = 25;
  localparam int LOW_HZ [4]  = '{697, 770, 852, 941};
  localparam int HIGH_HZ [4] = '{1209, 1336, 1477, 1633};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lowTone = 1'b0;
  logic       highTone = 1'b0;
  logic       earlySteer;
  logic [3:0] digitCode;

  int lowPer = 0;
  int highPer = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dtmf_pair_decoder i_dtmf_pair_decoder (
    .clk(clk), .rstN(rstN), .lowTone(lowTone), .highTone(highTone),
    .earlySteer(earlySteer), .digitCode(digitCode)
  );

  function automatic int winMin(input int f);
    return int'((longint'(CLK_HZ) * 1000) / (longint'(f) * (1000 + TOL)));
  endfunction
  function automatic int winMax(input int f);
    return int'((longint'(CLK_HZ) * 1000) / (longint'(f) * (1000 - TOL)));
  endfunction
  function automatic int nomPer(input int f);
    return (CLK_HZ + f / 2) / f;
  endfunction

  localparam int TIMEOUT = 2 * 294;

  // Square-wave generators, period counted in clock cycles.
  initial forever begin
    if (lowPer == 0) begin
      lowTone = 1'b0; @(negedge clk);
    end else begin
      lowTone = 1'b1; repeat (lowPer / 2) @(negedge clk);
      lowTone = 1'b0; repeat (lowPer - lowPer / 2) @(negedge clk);
    end
  end
  initial forever begin
    if (highPer == 0) begin
      highTone = 1'b0; @(negedge clk);
    end else begin
      highTone = 1'b1; repeat (highPer / 2) @(negedge clk);
      highTone = 1'b0; repeat (highPer - highPer / 2) @(negedge clk);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic goIdle();
    lowPer = 0; highPer = 0;
    waitCycles(TIMEOUT + 60);
  endtask

  task automatic testReset();
    check("R9", "reset earlySteer", int'(earlySteer), 0);
    check("R9", "reset digitCode", int'(digitCode), 0);
  endtask

  // R1 R2 R6 R8 R9: hold a pair, check the code, then release and check hold.
  task automatic testPair(input int row, input int col, input int expCode);
    lowPer = nomPer(LOW_HZ[row]); highPer = nomPer(HIGH_HZ[col]);
    waitCycles(2500);
    check("R6", $sformatf("est for r%0d c%0d", row, col), int'(earlySteer), 1);
    check("R8", $sformatf("code for r%0d c%0d", row, col), int'(digitCode), expCode);
    goIdle();
    check("R5", "est after both stop", int'(earlySteer), 0);
    check("R9", "code held after release", int'(digitCode), expCode);
  endtask

  // R3: not accepted before VALID_RUN periods, accepted afterwards.
  task automatic testShortBurst();
    lowPer = nomPer(697); highPer = nomPer(1209);
    waitCycles(900);
    check("R3", "est after three low periods", int'(earlySteer), 0);
    waitCycles(1600);
    check("R3", "est after full run", int'(earlySteer), 1);
    goIdle();
  endtask

  // R2 boundaries on the 697 Hz window, R4 outside every window.
  task automatic testWindow(input int per, input int expEst, input string what);
    lowPer = per; highPer = nomPer(1336);
    waitCycles(2800);
    check(expEst != 0 ? "R2" : "R4", what, int'(earlySteer), expEst);
    goIdle();
  endtask

  // R6: one group alone never steers.
  task automatic testSingleGroup();
    lowPer = 0; highPer = nomPer(1477);
    waitCycles(2000);
    check("R6", "est with high group only", int'(earlySteer), 0);
    goIdle();
  endtask

  // R5 R7: high group stops while pair is held.
  task automatic testDropout();
    lowPer = nomPer(852); highPer = nomPer(1209);
    waitCycles(2500);
    check("R6", "est before high stops", int'(earlySteer), 1);
    highPer = 0;
    waitCycles(TIMEOUT / 2);
    check("R5", "est before timeout expires", int'(earlySteer), 1);
    waitCycles(TIMEOUT / 2 + 200);
    check("R7", "est after high timeout", int'(earlySteer), 0);
    goIdle();
  endtask

  // R7 R4: high group jumps to an out-of-band rate.
  task automatic testOutOfBandJump();
    lowPer = nomPer(770); highPer = nomPer(1633);
    waitCycles(2500);
    check("R6", "est before jump", int'(earlySteer), 1);
    highPer = 100;
    waitCycles(300);
    check("R7", "est after out-of-band high", int'(earlySteer), 0);
    check("R9", "code held after loss", int'(digitCode), 14);
    goIdle();
  endtask

  // R10: window change restarts the run, new code after re-validation.
  task automatic testBinChange();
    lowPer = nomPer(697); highPer = nomPer(1209);
    waitCycles(2500);
    check("R6", "est before change", int'(earlySteer), 1);
    highPer = nomPer(1336);
    waitCycles(400);
    check("R10", "est right after window change", int'(earlySteer), 0);
    waitCycles(1500);
    check("R10", "est after new run", int'(earlySteer), 1);
    check("R10", "code after new run", int'(digitCode), 2);
    goIdle();
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCycles(5);
    testReset();
    rstN = 1'b1;
    waitCycles(5);
    testReset();
    testPair(0, 0, 1);
    testPair(1, 1, 5);
    testPair(2, 2, 9);
    testPair(3, 1, 10);
    testPair(3, 0, 11);
    testPair(3, 2, 12);
    testPair(0, 3, 13);
    testPair(3, 3, 0);
    testShortBurst();
    testWindow(winMin(697), 1, "low at window minimum");
    testWindow(winMax(697), 1, "low at window maximum");
    testWindow(winMin(697) - 1, 0, "low just below window");
    testWindow(winMax(697) + 1, 0, "low just above window");
    testWindow(275, 0, "low between windows");
    testSingleGroup();
    testDropout();
    testOutOfBandJump();
    testBinChange();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule